// File: doc/BRIEF.md
# Latching Fault Status Word with Text Command Port

This block holds the 16-bit status word of a four-channel output controller. It mirrors four mode flags and the live state of each output channel. It also keeps two fault flags that latch, one for the external interlock and one for over-temperature, plus a summary fault that is the sticky OR of both. While the summary fault is set, every channel output is held off, whatever the enable requests ask for.

Software talks to the block over a byte stream that carries text lines. A query line returns the status word as four uppercase hex digits. A clear line drops the latched faults and returns a short acknowledgment. Both streams use a valid/ready handshake. The block takes no new input bytes while a reply is still going out.

Top module: `fault_status_ctrl`

## Requirements
- R1: Status word layout: bit 15 = remote control mode, bit 14 = interlock check enabled, bit 13 = trigger mode, bit 12 = gate mode, bits 11:8 = effective enables of channels 3..0, bit 7 = summary fault, bit 1 = over-temperature fault, bit 0 = interlock fault, and bits 6:2 read 0. Mode bits follow their inputs one clock later.
- R2: The interlock fault is set on the clock after a cycle in which the interlock check enable and the interlock pin are both high. With the check disabled, the pin has no effect. Once set, the fault holds until it is cleared.
- R3: The over-temperature fault is set on the clock after a cycle in which the comparator input is high, and it holds until it is cleared.
- R4: The summary fault is set on the same clock edge as any specific fault, and it stays set until a clear.
- R5: With no summary fault, each channel output follows its request one clock later. While the summary fault is set, all channel outputs are 0 and requests are ignored.
- R6: The line `STATUS:?` CR LF is answered with `STATUS:` followed by four uppercase hex digits of the status word (most significant first), then CR LF.
- R7: The line `STATUS:RESET` CR LF clears bits 7, 1 and 0 and is answered with `OK` CR LF.
- R8: A fault condition present in the same cycle as a clear wins, and its flags stay latched.
- R9: Any other line is discarded at its LF, with no reply and no change of state.
- R10: Reply bytes go out one per handshake, and the byte is held while the consumer stalls. The input ready signal is low from the accepted LF of a recognized command until the last reply byte is taken.
- R11: A synchronous active-high reset clears the faults, the mode bits and the channel outputs, and leaves no reply pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| remote_mode_i | input | 1 | Remote control mode flag |
| ilk_chk_en_i | input | 1 | Enables interlock checking |
| trig_mode_i | input | 1 | Trigger mode flag |
| gate_mode_i | input | 1 | Gate mode flag |
| ch_req_i | input | 4 | Requested channel enables |
| ilk_pin_i | input | 1 | External interlock input, high = tripped |
| overtemp_i | input | 1 | Over-temperature comparator output |
| rx_valid_i | input | 1 | Input byte valid |
| rx_data_i | input | 8 | Input byte |
| rx_ready_o | output | 1 | Block accepts an input byte |
| ch_en_o | output | 4 | Effective channel enables |
| tx_valid_o | output | 1 | Reply byte valid |
| tx_data_o | output | 8 | Reply byte |
| tx_ready_i | input | 1 | Consumer takes the reply byte |

## Verification
The query path is driven with several mode and channel patterns. Each pattern gives a different hex digit in each nibble, so a swapped or misplaced field shows in the reply text. The faults are tripped one at a time: an interlock pulse with checking off and then on, and an over-temperature pulse. This tells the enable gating apart from the latch itself. Lines that match a command only up to a late character show that a near miss gets no reply and changes nothing. A clear issued while the over-temperature input is still high tells "fault wins" apart from "clear wins". The consumer stalls on a fixed pattern, which checks that each reply byte is held and that input is blocked.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int NUM_CH   = 4;
  localparam int POS_W    = 5;
  localparam int QRY_LEN  = 9;   // bytes before LF in the query line
  localparam int CLR_LEN  = 13;  // bytes before LF in the clear line
  localparam int QREP_LEN = 13;
  localparam int ACK_LEN  = 4;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;

  // expected character of a command line at a position
  function automatic logic [7:0] cmd_char(input logic is_clr, input logic [POS_W-1:0] i);
    logic [7:0] c;
    case (i)
      5'd0: c = "S";
      5'd1: c = "T";
      5'd2: c = "A";
      5'd3: c = "T";
      5'd4: c = "U";
      5'd5: c = "S";
      5'd6: c = ":";
      default: begin
        if (is_clr) begin
          case (i)
            5'd7:  c = "R";
            5'd8:  c = "E";
            5'd9:  c = "S";
            5'd10: c = "E";
            5'd11: c = "T";
            5'd12: c = CH_CR;
            default: c = 8'h00;
          endcase
        end else begin
          case (i)
            5'd7: c = "?";
            5'd8: c = CH_CR;
            default: c = 8'h00;
          endcase
        end
      end
    endcase
    return c;
  endfunction

  function automatic logic [7:0] hex_char(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  function automatic logic [7:0] reply_char(input logic is_ack, input logic [POS_W-1:0] i,
                                            input logic [15:0] w);
    logic [7:0] c;
    if (is_ack) begin
      case (i)
        5'd0: c = "O";
        5'd1: c = "K";
        5'd2: c = CH_CR;
        default: c = CH_LF;
      endcase
    end else begin
      case (i)
        5'd7:  c = hex_char(w[15:12]);
        5'd8:  c = hex_char(w[11:8]);
        5'd9:  c = hex_char(w[7:4]);
        5'd10: c = hex_char(w[3:0]);
        5'd11: c = CH_CR;
        5'd12: c = CH_LF;
        default: c = cmd_char(1'b0, i);
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/fsc_fault_latch.sv
module fsc_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic ilk_chk_en,
  input  logic ilk_pin,
  input  logic overtemp,
  input  logic clear,
  output logic ilk_flt_q,
  output logic ot_flt_q,
  output logic sum_flt_q,
  output logic sum_flt_next
);
  logic ilk_set, ot_set;
  logic ilk_next, ot_next;

  always_comb begin
    ilk_set      = ilk_chk_en & ilk_pin;
    ot_set       = overtemp;
    // a present condition beats a clear in the same cycle
    ilk_next     = (ilk_flt_q & ~clear) | ilk_set;
    ot_next      = (ot_flt_q & ~clear) | ot_set;
    sum_flt_next = (sum_flt_q & ~clear) | ilk_set | ot_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ilk_flt_q <= 1'b0;
      ot_flt_q  <= 1'b0;
      sum_flt_q <= 1'b0;
    end else begin
      ilk_flt_q <= ilk_next;
      ot_flt_q  <= ot_next;
      sum_flt_q <= sum_flt_next;
    end
  end
endmodule

// File: rtl/fsc_cmd_parser.sv
module fsc_cmd_parser
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic [7:0] data,
  output logic       cmd_query,
  output logic       cmd_clear
);
  logic [POS_W-1:0] pos_q;
  logic             qry_ok_q, clr_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      qry_ok_q  <= 1'b1;
      clr_ok_q  <= 1'b1;
      cmd_query <= 1'b0;
      cmd_clear <= 1'b0;
    end else begin
      cmd_query <= 1'b0;
      cmd_clear <= 1'b0;
      if (accept) begin
        if (data == CH_LF) begin
          cmd_query <= qry_ok_q && (pos_q == POS_W'(QRY_LEN));
          cmd_clear <= clr_ok_q && (pos_q == POS_W'(CLR_LEN));
          pos_q     <= '0;
          qry_ok_q  <= 1'b1;
          clr_ok_q  <= 1'b1;
        end else begin
          qry_ok_q <= qry_ok_q && (pos_q < POS_W'(QRY_LEN)) && (data == cmd_char(1'b0, pos_q));
          clr_ok_q <= clr_ok_q && (pos_q < POS_W'(CLR_LEN)) && (data == cmd_char(1'b1, pos_q));
          if (pos_q != '1) pos_q <= pos_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsc_reply_tx.sv
module fsc_reply_tx
  import fsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start_query,
  input  logic        start_ack,
  input  logic [15:0] word,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data
);
  logic             is_ack_q;
  logic [15:0]      snap_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] last_pos;

  assign last_pos = is_ack_q ? POS_W'(ACK_LEN - 1) : POS_W'(QREP_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      is_ack_q <= 1'b0;
      snap_q   <= '0;
      pos_q    <= '0;
      tx_data  <= '0;
    end else if (!tx_valid) begin
      if (start_query || start_ack) begin
        tx_valid <= 1'b1;
        is_ack_q <= start_ack;
        snap_q   <= word;
        pos_q    <= '0;
        tx_data  <= reply_char(start_ack, '0, word);
      end
    end else if (tx_ready) begin
      if (pos_q == last_pos) begin
        tx_valid <= 1'b0;
      end else begin
        pos_q   <= pos_q + 1'b1;
        tx_data <= reply_char(is_ack_q, pos_q + 1'b1, snap_q);
      end
    end
  end
endmodule

// File: rtl/fault_status_ctrl.sv
module fault_status_ctrl
  import fsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              remote_mode_i,
  input  logic              ilk_chk_en_i,
  input  logic              trig_mode_i,
  input  logic              gate_mode_i,
  input  logic [NUM_CH-1:0] ch_req_i,
  input  logic              ilk_pin_i,
  input  logic              overtemp_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i
);
  logic [3:0]  mode_q;
  logic        ilk_flt, ot_flt, sum_flt, sum_next;
  logic        cmd_query, cmd_clear;
  logic [15:0] status_w;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else     mode_q <= {remote_mode_i, ilk_chk_en_i, trig_mode_i, gate_mode_i};
  end

  fsc_fault_latch u_latch (
    .clk          (clk),
    .rst          (rst),
    .ilk_chk_en   (ilk_chk_en_i),
    .ilk_pin      (ilk_pin_i),
    .overtemp     (overtemp_i),
    .clear        (cmd_clear),
    .ilk_flt_q    (ilk_flt),
    .ot_flt_q     (ot_flt),
    .sum_flt_q    (sum_flt),
    .sum_flt_next (sum_next)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) ch_en_o[g] <= 1'b0;
      else     ch_en_o[g] <= ch_req_i[g] & ~sum_next;
    end
  end

  assign status_w = {mode_q, ch_en_o, sum_flt, 5'b00000, ot_flt, ilk_flt};

  assign rx_ready_o = ~(cmd_query | cmd_clear | tx_valid_o);

  fsc_cmd_parser u_parse (
    .clk       (clk),
    .rst       (rst),
    .accept    (rx_valid_i & rx_ready_o),
    .data      (rx_data_i),
    .cmd_query (cmd_query),
    .cmd_clear (cmd_clear)
  );

  fsc_reply_tx u_tx (
    .clk         (clk),
    .rst         (rst),
    .start_query (cmd_query),
    .start_ack   (cmd_clear),
    .word        (status_w),
    .tx_ready    (tx_ready_i),
    .tx_valid    (tx_valid_o),
    .tx_data     (tx_data_o)
  );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] stat_lo,
  input logic [3:0] ch_en,
  input logic       ilk_chk_en,
  input logic       ilk_pin,
  input logic       overtemp,
  input logic       clear,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst) stat_lo[6:2] == 5'b0);
  // R2
  ilk_latch_chk: assert property (@(posedge clk) disable iff (rst) (ilk_chk_en && ilk_pin) |=> stat_lo[0]);
  // R3
  ot_latch_chk: assert property (@(posedge clk) disable iff (rst) overtemp |=> stat_lo[1]);
  // R4
  summary_or_chk: assert property (@(posedge clk) disable iff (rst) (stat_lo[1:0] != 2'b00) |-> stat_lo[7]);
  // R4
  summary_sticky_chk: assert property (@(posedge clk) disable iff (rst) (stat_lo[7] && !clear) |=> stat_lo[7]);
  // R5
  ch_forced_off_chk: assert property (@(posedge clk) disable iff (rst) stat_lo[7] |-> (ch_en == 4'b0));
  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

bind fault_status_ctrl fsc_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .stat_lo    (status_w[7:0]),
  .ch_en      (ch_en_o),
  .ilk_chk_en (ilk_chk_en_i),
  .ilk_pin    (ilk_pin_i),
  .overtemp   (overtemp_i),
  .clear      (cmd_clear),
  .tx_valid   (tx_valid_o),
  .tx_ready   (tx_ready_i),
  .tx_data    (tx_data_o)
);

// File: tb/fault_status_ctrl_tb.sv
module fault_status_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       remote_mode = 0, ilk_chk_en = 0, trig_mode = 0, gate_mode = 0;
  logic [3:0] ch_req = 4'h0;
  logic       ilk_pin = 0, overtemp = 0;
  logic       rx_valid = 0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ready;
  logic [3:0] ch_en;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string cur_tag = "R6";
  int stall_cnt = 0;
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = 8'h00;

  always #4 clk = ~clk;

  fault_status_ctrl u_dut (
    .clk(clk), .rst(rst),
    .remote_mode_i(remote_mode), .ilk_chk_en_i(ilk_chk_en),
    .trig_mode_i(trig_mode), .gate_mode_i(gate_mode),
    .ch_req_i(ch_req), .ilk_pin_i(ilk_pin), .overtemp_i(overtemp),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .ch_en_o(ch_en), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) check(tx_valid && tx_data == prev_data, "R10 hold", tx_data, prev_data);
      if (tx_valid && rx_ready) check(1'b0, "R10 rx_ready", 1, 0);
      stall_cnt++;
      tx_ready = (stall_cnt % 3) != 0;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) check(1'b0, {cur_tag, " unexpected byte"}, tx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(tx_data == e, cur_tag, tx_data, e);
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
    end
  end

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) put_byte(s[i]);
  endtask

  task automatic expect_str(input string s);
    for (int i = 0; i < s.len(); i++) exp_q.push_back(s[i]);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !tx_valid) break;
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, {cur_tag, " reply complete"}, exp_q.size(), 0);
  endtask

  task automatic query(input string hex, input string tag);
    cur_tag = tag;
    expect_str({"STATUS:", hex, "\015\012"});
    send_str("STATUS:?\015\012");
    wait_idle();
  endtask

  task automatic pulse_ilk();
    @(negedge clk); ilk_pin = 1'b1;
    @(negedge clk); ilk_pin = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(ch_en == 4'h0, "R11 ch_en", ch_en, 0);
    check(!tx_valid, "R11 tx_valid", tx_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rx_ready, "R11 rx_ready", rx_ready, 1);

    // R1 R5 R6: modes and channels reflected
    remote_mode = 1; trig_mode = 1; ch_req = 4'b1011;
    repeat (2) @(negedge clk);
    check(ch_en == 4'b1011, "R5 follow", ch_en, 4'b1011);
    query("AB00", "R1 R6 layout");
    gate_mode = 1; remote_mode = 0; trig_mode = 0; ch_req = 4'b0100;
    repeat (2) @(negedge clk);
    query("1400", "R1 R6 layout2");
    gate_mode = 0; remote_mode = 1; trig_mode = 1; ch_req = 4'b1011;
    repeat (2) @(negedge clk);

    // R2: interlock ignored while checking is disabled
    pulse_ilk();
    repeat (2) @(negedge clk);
    check(ch_en == 4'b1011, "R2 disabled", ch_en, 4'b1011);
    query("AB00", "R2 no fault");

    // R2 R4 R5: enabled interlock latches
    ilk_chk_en = 1;
    repeat (2) @(negedge clk);
    pulse_ilk();
    @(negedge clk);
    check(ch_en == 4'h0, "R5 forced off", ch_en, 0);
    ch_req = 4'hF;
    repeat (3) @(negedge clk);
    check(ch_en == 4'h0, "R5 requests ignored", ch_en, 0);
    query("E081", "R2 R4 latched");

    // R9: near-miss lines produce nothing and change nothing
    cur_tag = "R9";
    send_str("STATUS:RESEX\015\012");
    send_str("STATUS:?X\015\012");
    send_str("STATUS:RESET\012");
    repeat (20) @(negedge clk);
    check(!tx_valid && ch_en == 4'h0, "R9 no effect", {tx_valid, ch_en}, 0);
    query("E081", "R9 state kept");

    // R7: clear command
    cur_tag = "R7 ack";
    expect_str("OK\015\012");
    send_str("STATUS:RESET\015\012");
    wait_idle();
    @(negedge clk);
    check(ch_en == 4'hF, "R7 channels back", ch_en, 4'hF);
    query("EF00", "R7 cleared");

    // R3: over-temperature
    @(negedge clk); overtemp = 1;
    @(negedge clk); overtemp = 0;
    @(negedge clk);
    check(ch_en == 4'h0, "R3 R5 off", ch_en, 0);
    query("E082", "R3 latched");

    // R8: fault present during clear wins
    overtemp = 1;
    cur_tag = "R8 ack";
    expect_str("OK\015\012");
    send_str("STATUS:RESET\015\012");
    wait_idle();
    query("E082", "R8 fault wins");
    overtemp = 0;
    cur_tag = "R8 ack2";
    expect_str("OK\015\012");
    send_str("STATUS:RESET\015\012");
    wait_idle();
    query("EF00", "R8 later clear");

    // R11: synchronous reset clears faults and modes
    pulse_ilk();
    @(negedge clk);
    remote_mode = 0; ilk_chk_en = 0; trig_mode = 0; gate_mode = 0; ch_req = 4'h0;
    rst = 1;
    repeat (2) @(negedge clk);
    check(ch_en == 4'h0 && !tx_valid, "R11 in reset", {tx_valid, ch_en}, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    query("0000", "R11 cleared");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule